// File: doc/BRIEF.md
# Lockable SMM-Only Memory Window Guard

This block sits on the chipset side of the memory path and guards a fixed 128 KiB region starting at physical address 0x30000, the area where processors place their default system-management save state. It owns one 8-bit control register on a byte-wide configuration port. Firmware first probes for the feature by writing all ones and reading back a presence code. It then sets a one-way lock bit. After that, only accesses made in system-management context can see the region.

Every memory access arrives with an address, a byte count, a write flag and an SMM-context flag. The block decides combinationally whether the access is forwarded to backing RAM or blocked. A blocked read returns all ones across the full data width. A blocked write is dropped, and no RAM request is raised for it. A parameter can remove the feature entirely. The register then never reports presence and the window is never blocked.

Top module: `smm_window_guard`

## Requirements
- R1: After synchronous reset the control register at config offset 0x9c reads 0x00, and non-SMM accesses to the window reach RAM.
- R2: With the feature enabled, writing 0xFF to offset 0x9c from the reset state makes the register read 0x01 (feature present, window still open) on the next cycle.
- R3: While the register is in its reset state, a write of any value other than 0xFF is discarded and the register stays 0x00.
- R4: After a successful query, only bit 1 (value 0x02) has an effect. A write with bit 1 set locks the window and the register reads 0x02. A write with bit 1 clear leaves it at 0x01.
- R5: Once locked, every write to the register is ignored, including 0xFF, until the next reset. Reset returns it to 0x00.
- R6: When locked, a non-SMM access in the window raises no RAM request. A read returns all ones on `mem_rdata`, and a write produces no `ram_req` or `ram_we`.
- R7: An SMM-context access always reaches RAM: `ram_req` is high and `mem_rdata` equals `ram_rdata`, whether or not the window is locked.
- R8: Before the lock is set, non-SMM accesses to the window reach RAM.
- R9: An access covers `mem_size`+1 bytes starting at `mem_addr`, where `mem_size` is 0 to 3. It counts as inside the window if any of its bytes lies in [0x30000, 0x4FFFF]. Accesses wholly outside that range always pass.
- R10: With `FEATURE_EN` = 0, a query write leaves the register at 0x00 and the window is never blocked.
- R11: Writes to config offsets other than 0x9c do not change the register, and reads of other offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 8 | Config byte offset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for `cfg_addr` (combinational) |
| mem_valid | input | 1 | Memory access present |
| mem_addr | input | 32 | Access start address |
| mem_size | input | 2 | Access length in bytes minus one |
| mem_we | input | 1 | Access is a write |
| mem_smm | input | 1 | Access comes from SMM context |
| ram_req | output | 1 | Forward access to RAM |
| ram_we | output | 1 | Forwarded write enable |
| ram_rdata | input | 32 | Read data from RAM |
| mem_rdata | output | 32 | Read data returned to requester |

## Verification
The assertions assume that `mem_size` and the address together never run past the top of the address space, and that configuration writes arrive as single-cycle strobes with the offset held stable. The bench drives each strobe for exactly one cycle and uses addresses near 0x30000 and 0x4FFFF, well below the wrap point. The bench also assumes the SMM flag is valid whenever `mem_valid` is high, so it sets all access fields together before it samples.

// File: rtl/smm_window_guard.sv
module smm_window_guard #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter bit FEATURE_EN = 1'b1,
  parameter logic [7:0] CFG_OFFSET = 8'h9c,
  parameter logic [AW-1:0] WIN_BASE = 32'h0003_0000,
  parameter logic [AW-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    cfg_addr,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_addr,
  input  logic [1:0]    mem_size,
  input  logic          mem_we,
  input  logic          mem_smm,
  output logic          ram_req,
  output logic          ram_we,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] mem_rdata
);
  localparam logic [AW:0] WIN_LO = {1'b0, WIN_BASE};
  localparam logic [AW:0] WIN_HI = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE} - 1'b1;
  localparam logic [7:0] VAL_PRESENT = 8'h01;
  localparam logic [7:0] VAL_LOCKED  = 8'h02;

  logic queried_q, locked_q;
  logic cfg_hit;
  logic [7:0] reg_val;
  logic [AW:0] first_b, last_b;
  logic in_win, blocked;

  assign cfg_hit = cfg_addr == CFG_OFFSET;

  always_ff @(posedge clk) begin
    if (rst) begin
      queried_q <= 1'b0;
      locked_q  <= 1'b0;
    end else if (FEATURE_EN && cfg_wr && cfg_hit && !locked_q) begin
      if (!queried_q) begin
        if (cfg_wdata == 8'hFF) queried_q <= 1'b1;
      end else if (cfg_wdata[1]) begin
        locked_q <= 1'b1;
      end
    end
  end

  assign reg_val   = locked_q ? VAL_LOCKED : (queried_q ? VAL_PRESENT : 8'h00);
  assign cfg_rdata = cfg_hit ? reg_val : 8'h00;

  assign first_b = {1'b0, mem_addr};
  assign last_b  = first_b + {{(AW-1){1'b0}}, mem_size};
  assign in_win  = (last_b >= WIN_LO) && (first_b <= WIN_HI);
  assign blocked = FEATURE_EN && locked_q && !mem_smm && in_win;

  assign ram_req   = mem_valid && !blocked;
  assign ram_we    = ram_req && mem_we;
  assign mem_rdata = blocked ? {DW{1'b1}} : ram_rdata;

  // reset value check
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (reg_val == 8'h00));

  p_query_present_r2: assert property (@(posedge clk) disable iff (rst)
    (FEATURE_EN && reg_val == 8'h00 && cfg_wr && cfg_hit && cfg_wdata == 8'hFF)
      |=> (reg_val == VAL_PRESENT));

  p_reset_state_discard_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_val == 8'h00 && cfg_wr && cfg_wdata != 8'hFF) |=> (reg_val == 8'h00));

  p_lock_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_val == VAL_LOCKED) |=> (reg_val == VAL_LOCKED));

  p_block_base_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_val == VAL_LOCKED && mem_valid && !mem_smm && mem_addr == WIN_BASE)
      |-> (!ram_req && !ram_we && mem_rdata == {DW{1'b1}}));

  p_smm_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_smm) |-> (ram_req && mem_rdata == ram_rdata));

  p_open_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_val != VAL_LOCKED && mem_valid) |-> ram_req);
endmodule

// File: tb/smm_window_guard_tb.sv
module smm_window_guard_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [7:0] cfg_addr, cfg_wdata;
  logic cfg_wr;
  logic mem_valid, mem_we, mem_smm;
  logic [31:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] ram_rdata;
  logic [7:0] cfg_rdata, d_cfg_rdata;
  logic ram_req, ram_we, d_ram_req, d_ram_we;
  logic [31:0] mem_rdata, d_mem_rdata;

  localparam logic [31:0] RAMV = 32'h1234_5678;

  smm_window_guard u_dut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_we(mem_we), .mem_smm(mem_smm), .ram_req(ram_req), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .mem_rdata(mem_rdata));

  smm_window_guard #(.FEATURE_EN(1'b0)) u_dis (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(d_cfg_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_we(mem_we), .mem_smm(mem_smm), .ram_req(d_ram_req), .ram_we(d_ram_we),
    .ram_rdata(ram_rdata), .mem_rdata(d_mem_rdata));

  typedef struct {
    int kind;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {24'h0, cfg_rdata};
        1: act = {31'h0, ram_req};
        2: act = mem_rdata;
        3: act = {24'h0, d_cfg_rdata};
        4: act = {31'h0, d_ram_req};
        default: act = {31'h0, ram_we};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int k, logic [31:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    mem_valid = 0; cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic exp_cfg(logic [7:0] a, logic [7:0] e, string t);
    @(negedge clk);
    cfg_wr = 0; cfg_addr = a; mem_valid = 0;
    push(0, {24'h0, e}, t);
  endtask

  task automatic exp_mem(logic [31:0] a, logic [1:0] sz, logic we, logic smm, logic pass, string t);
    @(negedge clk);
    cfg_wr = 0; mem_valid = 1; mem_addr = a; mem_size = sz; mem_we = we; mem_smm = smm;
    push(1, {31'h0, pass}, t);
    push(5, {31'h0, pass && we}, t);
    if (!we) push(2, pass ? RAMV : 32'hFFFF_FFFF, t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cfg_wr = 0; mem_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_addr = 0; cfg_wdata = 0; cfg_wr = 0;
    mem_valid = 0; mem_addr = 0; mem_size = 0; mem_we = 0; mem_smm = 0;
    ram_rdata = RAMV;
    do_reset();
    exp_cfg(8'h9c, 8'h00, "R1 reset value");
    exp_mem(32'h30000, 2'd3, 0, 0, 1, "R1 open after reset");
    cfg_write(8'h9c, 8'h5A);
    exp_cfg(8'h9c, 8'h00, "R3 discard 0x5A");
    cfg_write(8'h9c, 8'h02);
    exp_cfg(8'h9c, 8'h00, "R3 discard 0x02");
    cfg_write(8'h9d, 8'hFF);
    exp_cfg(8'h9c, 8'h00, "R11 other offset write");
    exp_cfg(8'h9d, 8'h00, "R11 other offset read");
    cfg_write(8'h9c, 8'hFF);
    exp_cfg(8'h9c, 8'h01, "R2 query present");
    @(negedge clk); push(3, 32'h0, "R10 disabled query stays 0");
    exp_cfg(8'h9d, 8'h00, "R11 other offset read after query");
    cfg_write(8'h9c, 8'h01);
    exp_cfg(8'h9c, 8'h01, "R4 bit1 clear keeps 0x01");
    cfg_write(8'h9c, 8'hFD);
    exp_cfg(8'h9c, 8'h01, "R4 0xFD keeps 0x01");
    exp_mem(32'h30000, 2'd3, 0, 0, 1, "R8 open before lock read");
    exp_mem(32'h3FFF0, 2'd3, 1, 0, 1, "R8 open before lock write");
    cfg_write(8'h9c, 8'h02);
    exp_cfg(8'h9c, 8'h02, "R4 lock reads 0x02");
    cfg_write(8'h9c, 8'hFF);
    exp_cfg(8'h9c, 8'h02, "R5 query after lock");
    cfg_write(8'h9c, 8'h00);
    exp_cfg(8'h9c, 8'h02, "R5 clear after lock");
    exp_mem(32'h30000, 2'd3, 0, 0, 0, "R6 blocked read base");
    exp_mem(32'h4FFFF, 2'd0, 0, 0, 0, "R6 blocked read top byte");
    exp_mem(32'h3FFF0, 2'd3, 1, 0, 0, "R6 blocked write");
    exp_mem(32'h2FFFF, 2'd0, 0, 0, 1, "R9 byte below window");
    exp_mem(32'h2FFFD, 2'd3, 0, 0, 0, "R9 straddle into window");
    exp_mem(32'h2FFFC, 2'd3, 0, 0, 1, "R9 word ending below window");
    exp_mem(32'h50000, 2'd3, 0, 0, 1, "R9 above window");
    exp_mem(32'h30000, 2'd3, 0, 1, 1, "R7 SMM read locked");
    exp_mem(32'h40000, 2'd1, 1, 1, 1, "R7 SMM write locked");
    @(negedge clk);
    mem_valid = 1; mem_addr = 32'h30000; mem_size = 0; mem_we = 0; mem_smm = 0;
    push(4, 32'h1, "R10 disabled never blocks");
    do_reset();
    exp_cfg(8'h9c, 8'h00, "R5 reset clears lock");
    exp_mem(32'h30000, 2'd3, 0, 0, 1, "R5 window open after reset");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule